// File: doc/BRIEF.md
# Store Queue with Separate Writeback Pointer

This block holds the stores of one thread of an out-of-order core between dispatch and the moment their data reaches the data cache. Stores take slots in program order at the tail. When a store executes, its slot captures the address, byte count and data. Commit reports the youngest committed sequence tag, and every older store becomes eligible to write. A dedicated writeback pointer walks the committed stores in order and presents one write per cycle to the cache port. A slot stays occupied until the cache returns a completion for its index. At that point the head moves past every contiguous completed slot.

Misspeculation is handled by a squash tag. Every uncommitted store younger than the tag is dropped, and the tail is pulled back by the number of dropped stores. The block reports its occupancy, how many committed stores still wait to be written, a full flag, and the write it presents in the current cycle.

Top module: `sq_store_queue`

## Requirements
- R1: After reset, occupancy and the pending-write count are 0, full is low, wb_valid is low and alloc_idx is 0.
- R2: An accepted allocation takes the slot shown on alloc_idx. alloc_idx then moves to the next slot and occupancy rises by one.
- R3: full is high whenever occupancy is at least DEPTH-1. While full is high, an allocation request is ignored: occupancy and alloc_idx do not change.
- R4: An execute on exec_idx records the address, byte count and data of that store. These same values appear on wb_addr, wb_size and wb_data when the store is written.
- R5: A commit with tag T marks every occupied, uncommitted slot whose tag is less than or equal to T as committed. wb_pending rises by the number of slots newly marked. A repeated commit marks nothing new.
- R6: wb_valid is high exactly when the slot at the writeback pointer is occupied, committed and not yet written, and cache_blocked is low. Writes leave in program order, each showing its slot on wb_idx. Each issued write moves the pointer by one slot and lowers wb_pending by one.
- R7: While cache_blocked is high, no write is presented and the writeback pointer holds.
- R8: A slot is not freed at commit or at write issue. A completion on done_idx marks its slot as written back. One cycle later the head passes every contiguous written-back slot at once, and occupancy drops by that number. A completion that arrives out of order frees nothing until all older slots are written back.
- R9: A squash with tag S drops every occupied, uncommitted slot whose tag is greater than S. The tail moves back by the number dropped, so the next allocation reuses the first dropped slot. Committed slots are never dropped.
- R10: Slot indices wrap from DEPTH-1 to 0.
- R11: If an allocation request and a squash arrive in the same cycle, the allocation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate a store slot |
| alloc_tag | input | 16 | Sequence tag of the allocated store |
| alloc_idx | output | PTR_W | Slot the next allocation takes (tail) |
| exec_valid | input | 1 | Store execute strobe |
| exec_idx | input | PTR_W | Slot of the executing store |
| exec_addr | input | 32 | Store address |
| exec_size | input | 4 | Store byte count |
| exec_data | input | 64 | Store data |
| commit_valid | input | 1 | Commit strobe |
| commit_tag | input | 16 | Youngest committed tag |
| squash_valid | input | 1 | Squash strobe |
| squash_tag | input | 16 | Stores with larger tags are dropped |
| cache_blocked | input | 1 | Cache cannot accept a write this cycle |
| wb_valid | output | 1 | A write is issued this cycle |
| wb_idx | output | PTR_W | Slot of the issued write |
| wb_addr | output | 32 | Write address |
| wb_size | output | 4 | Write byte count |
| wb_data | output | 64 | Write data |
| done_valid | input | 1 | Write completion response |
| done_idx | input | PTR_W | Slot whose write completed |
| occupancy | output | CNT_W | Occupied slots |
| wb_pending | output | CNT_W | Committed stores not yet written |
| full | output | 1 | Occupancy at least DEPTH-1 |

## Verification
The write path runs twice. The first run is a short burst of two stores starting from slot 0, released after being held by cache_blocked. The second is a full queue of seven stores that wraps past the last slot. Comparing the scoreboard against wb_* in both runs separates correct in-order draining from pointer-wrap errors. Completions are sent out of order and then in order, which tells apart freeing at completion from freeing at issue or commit, and a single-slot head step from a contiguous multi-slot step. Squashes are sent with a tag that drops only uncommitted stores, with a tag below the committed ones, and together with an allocation. Repeated commits of the same tag show whether wb_pending counts only newly committed slots.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int unsigned SQ_TAG_W  = 16;
    localparam int unsigned SQ_ADDR_W = 32;
    localparam int unsigned SQ_SIZE_W = 4;
    localparam int unsigned SQ_DATA_W = 64;

    typedef logic [SQ_TAG_W-1:0]  sq_tag_t;
    typedef logic [SQ_ADDR_W-1:0] sq_addr_t;
    typedef logic [SQ_SIZE_W-1:0] sq_size_t;
    typedef logic [SQ_DATA_W-1:0] sq_data_t;

    typedef struct packed {
        logic     valid;
        sq_tag_t  tag;
        sq_addr_t addr;
        sq_size_t size;
        sq_data_t data;
        logic     can_wb;
        logic     committed;
        logic     completed;
    } sq_slot_t;

    // circular add, n no larger than depth
    function automatic int unsigned sq_wrap_add(int unsigned p, int unsigned n,
                                                int unsigned depth);
        int unsigned s;
        s = p + n;
        return (s >= depth) ? s - depth : s;
    endfunction

    // circular subtract, n no larger than depth
    function automatic int unsigned sq_wrap_sub(int unsigned p, int unsigned n,
                                                int unsigned depth);
        return (p >= n) ? p - n : p + depth - n;
    endfunction

endpackage

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     alloc_en,
    input  sq_tag_t  alloc_tag,
    input  logic     exec_en,
    input  sq_addr_t exec_addr,
    input  sq_size_t exec_size,
    input  sq_data_t exec_data,
    input  logic     commit_valid,
    input  sq_tag_t  commit_tag,
    input  logic     squash_valid,
    input  sq_tag_t  squash_tag,
    input  logic     done_en,
    input  logic     free_en,
    output sq_slot_t slot,
    output logic     commit_hit,
    output logic     squash_hit
);

    sq_slot_t s_q;

    assign slot = s_q;

    always_comb begin
        commit_hit = commit_valid && s_q.valid && !s_q.committed &&
                     (s_q.tag <= commit_tag);
        squash_hit = squash_valid && s_q.valid && !s_q.committed && !commit_hit &&
                     (s_q.tag > squash_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (free_en) begin
            s_q <= '0;
        end else if (alloc_en) begin
            s_q       <= '0;
            s_q.valid <= 1'b1;
            s_q.tag   <= alloc_tag;
        end else begin
            if (exec_en && s_q.valid) begin
                s_q.addr <= exec_addr;
                s_q.size <= exec_size;
                s_q.data <= exec_data;
            end
            if (commit_hit) begin
                s_q.committed <= 1'b1;
                s_q.can_wb    <= 1'b1;
            end
            if (squash_hit) begin
                s_q.valid <= 1'b0;
            end
            if (done_en && s_q.valid) begin
                s_q.completed <= 1'b1;
            end
        end
    end

    AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        s_q.completed |-> s_q.committed); // R8

    AST_COMMITTED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (s_q.valid && s_q.committed && !free_en) |=> (s_q.valid && s_q.committed)); // R9

endmodule

// File: rtl/sq_retire_scan.sv
module sq_retire_scan
    import sq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3,
    parameter int unsigned CNT_W = 4
) (
    input  logic [PTR_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [DEPTH-1:0] done_vec,
    output logic [CNT_W-1:0] run,
    output logic [DEPTH-1:0] free_mask
);

    logic        open_run;
    int unsigned pos;

    always_comb begin
        free_mask = '0;
        run       = '0;
        open_run  = 1'b1;
        pos       = 0;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            pos = sq_wrap_add(32'(head), i, DEPTH);
            if (open_run && (i < 32'(count)) && done_vec[pos]) begin
                free_mask[pos] = 1'b1;
                run            = run + CNT_W'(1);
            end else begin
                open_run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
    import sq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [SQ_TAG_W-1:0]  alloc_tag,
    output logic [PTR_W-1:0]     alloc_idx,
    input  logic                 exec_valid,
    input  logic [PTR_W-1:0]     exec_idx,
    input  logic [SQ_ADDR_W-1:0] exec_addr,
    input  logic [SQ_SIZE_W-1:0] exec_size,
    input  logic [SQ_DATA_W-1:0] exec_data,
    input  logic                 commit_valid,
    input  logic [SQ_TAG_W-1:0]  commit_tag,
    input  logic                 squash_valid,
    input  logic [SQ_TAG_W-1:0]  squash_tag,
    input  logic                 cache_blocked,
    output logic                 wb_valid,
    output logic [PTR_W-1:0]     wb_idx,
    output logic [SQ_ADDR_W-1:0] wb_addr,
    output logic [SQ_SIZE_W-1:0] wb_size,
    output logic [SQ_DATA_W-1:0] wb_data,
    input  logic                 done_valid,
    input  logic [PTR_W-1:0]     done_idx,
    output logic [CNT_W-1:0]     occupancy,
    output logic [CNT_W-1:0]     wb_pending,
    output logic                 full
);

    logic [PTR_W-1:0] head_q, tail_q, wbp_q;
    logic [CNT_W-1:0] cnt_q, pend_q;

    sq_slot_t         slots [DEPTH];
    logic [DEPTH-1:0] commit_hits, squash_hits, done_vec, free_mask;
    logic [CNT_W-1:0] run, commit_n, squash_n;
    logic             alloc_acc, will_wb;
    sq_slot_t         wb_slot;

    assign full      = (cnt_q >= CNT_W'(DEPTH - 1));
    assign alloc_acc = alloc_valid && !full && !squash_valid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sq_slot u_slot (
            .clk          (clk),
            .rst          (rst),
            .alloc_en     (alloc_acc && (tail_q == PTR_W'(g))),
            .alloc_tag    (alloc_tag),
            .exec_en      (exec_valid && (exec_idx == PTR_W'(g))),
            .exec_addr    (exec_addr),
            .exec_size    (exec_size),
            .exec_data    (exec_data),
            .commit_valid (commit_valid),
            .commit_tag   (commit_tag),
            .squash_valid (squash_valid),
            .squash_tag   (squash_tag),
            .done_en      (done_valid && (done_idx == PTR_W'(g))),
            .free_en      (free_mask[g]),
            .slot         (slots[g]),
            .commit_hit   (commit_hits[g]),
            .squash_hit   (squash_hits[g])
        );
        assign done_vec[g] = slots[g].valid && slots[g].completed;
    end

    sq_retire_scan #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_scan (
        .head      (head_q),
        .count     (cnt_q),
        .done_vec  (done_vec),
        .run       (run),
        .free_mask (free_mask)
    );

    assign commit_n = CNT_W'($countones(commit_hits));
    assign squash_n = CNT_W'($countones(squash_hits));

    assign wb_slot  = slots[wbp_q];
    assign will_wb  = wb_slot.valid && wb_slot.can_wb && !wb_slot.completed &&
                      !cache_blocked;

    assign wb_valid   = will_wb;
    assign wb_idx     = wbp_q;
    assign wb_addr    = wb_slot.addr;
    assign wb_size    = wb_slot.size;
    assign wb_data    = wb_slot.data;
    assign alloc_idx  = tail_q;
    assign occupancy  = cnt_q;
    assign wb_pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            wbp_q  <= '0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            head_q <= PTR_W'(sq_wrap_add(32'(head_q), 32'(run), DEPTH));
            if (squash_valid) begin
                tail_q <= PTR_W'(sq_wrap_sub(32'(tail_q), 32'(squash_n), DEPTH));
            end else if (alloc_acc) begin
                tail_q <= PTR_W'(sq_wrap_add(32'(tail_q), 1, DEPTH));
            end
            if (will_wb) begin
                wbp_q <= PTR_W'(sq_wrap_add(32'(wbp_q), 1, DEPTH));
            end
            cnt_q  <= cnt_q + CNT_W'(alloc_acc) - run - squash_n;
            pend_q <= pend_q + commit_n - CNT_W'(will_wb);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH - 1)); // R3

    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (rst)
        (full && alloc_valid && !squash_valid) |=> (tail_q == $past(tail_q))); // R3

    AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend_q <= cnt_q); // R5

    AST_WB_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (32'(wb_idx) == sq_wrap_add(32'($past(wb_idx)), 1, DEPTH))); // R6

    AST_WB_NOT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !cache_blocked); // R7

    AST_BLOCK_HOLDS_WBP: assert property (@(posedge clk) disable iff (rst)
        cache_blocked |=> (wbp_q == $past(wbp_q))); // R7

endmodule

// File: tb/sq_store_queue_tb_top.sv
module sq_store_queue_tb_top;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic        alloc_valid, exec_valid, commit_valid, squash_valid;
    logic        cache_blocked, done_valid, wb_valid, full;
    logic [15:0] alloc_tag, commit_tag, squash_tag;
    logic [2:0]  alloc_idx, exec_idx, wb_idx, done_idx;
    logic [31:0] exec_addr, wb_addr;
    logic [3:0]  exec_size, wb_size, occupancy, wb_pending;
    logic [63:0] exec_data, wb_data;

    sq_store_queue dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_idx(alloc_idx),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .exec_size(exec_size), .exec_data(exec_data),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .squash_valid(squash_valid), .squash_tag(squash_tag),
        .cache_blocked(cache_blocked),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_addr(wb_addr),
        .wb_size(wb_size), .wb_data(wb_data),
        .done_valid(done_valid), .done_idx(done_idx),
        .occupancy(occupancy), .wb_pending(wb_pending), .full(full)
    );

    typedef struct {
        logic [15:0] tag;
        logic [2:0]  idx;
        logic [31:0] addr;
        logic [3:0]  size;
        logic [63:0] data;
    } wexp_t;

    wexp_t pend_q[$];   // executed, not yet committed (program order)
    wexp_t sb_q[$];     // expected writes

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid = 0; exec_valid = 0; commit_valid = 0;
        squash_valid = 0; done_valid = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        clear_in();
        #1;
    endtask

    task automatic do_alloc(logic [15:0] tag, logic [2:0] exp_idx, string req);
        @(negedge clk);
        clear_in();
        alloc_valid = 1; alloc_tag = tag;
        #1;
        chk(req, 64'(alloc_idx), 64'(exp_idx));
    endtask

    task automatic do_exec(logic [2:0] idx, logic [15:0] tag);
        wexp_t e;
        @(negedge clk);
        clear_in();
        e.tag  = tag;
        e.idx  = idx;
        e.addr = 32'h1000 + 32'(tag) * 8;
        e.size = 4'(1 << (tag % 4));
        e.data = {32'hC0DE0000 | 32'(tag), 32'(tag) * 3};
        exec_valid = 1; exec_idx = idx;
        exec_addr = e.addr; exec_size = e.size; exec_data = e.data;
        pend_q.push_back(e);
    endtask

    task automatic do_commit(logic [15:0] tag);
        @(negedge clk);
        clear_in();
        commit_valid = 1; commit_tag = tag;
        while (pend_q.size() > 0 && pend_q[0].tag <= tag)
            sb_q.push_back(pend_q.pop_front());
    endtask

    task automatic do_squash(logic [15:0] tag);
        @(negedge clk);
        clear_in();
        squash_valid = 1; squash_tag = tag;
        while (pend_q.size() > 0 && pend_q[pend_q.size()-1].tag > tag)
            void'(pend_q.pop_back());
    endtask

    task automatic do_done(logic [2:0] idx);
        @(negedge clk);
        clear_in();
        done_valid = 1; done_idx = idx;
    endtask

    task automatic drain(int cycles);
        @(negedge clk);
        clear_in();
        cache_blocked = 0;
        for (int i = 0; i < cycles; i++) settle();
        cache_blocked = 1;
    endtask

    // scoreboard monitor: one expected item per issued write
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst === 1'b0 && wb_valid === 1'b1) begin
                chk("R7 write while blocked", 64'(cache_blocked), 64'd0);
                if (sb_q.size() == 0) begin
                    chk("R6 unexpected write", 64'd1, 64'd0);
                end else begin
                    wexp_t e;
                    e = sb_q.pop_front();
                    chk("R6 wb_idx order", 64'(wb_idx), 64'(e.idx));
                    chk("R4 wb_addr", 64'(wb_addr), 64'(e.addr));
                    chk("R4 wb_size", 64'(wb_size), 64'(e.size));
                    chk("R4 wb_data", wb_data, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_in();
        alloc_tag = 0; commit_tag = 0; squash_tag = 0;
        exec_idx = 0; exec_addr = 0; exec_size = 0; exec_data = 0; done_idx = 0;
        cache_blocked = 1;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 occupancy", 64'(occupancy), 0);
        chk("R1 wb_pending", 64'(wb_pending), 0);
        chk("R1 full", 64'(full), 0);
        chk("R1 wb_valid", 64'(wb_valid), 0);
        chk("R1 alloc_idx", 64'(alloc_idx), 0);

        // R2 allocation in order
        for (int k = 0; k < 4; k++) do_alloc(16'(10 + k), 3'(k), "R2 alloc_idx");
        settle();
        chk("R2 occupancy", 64'(occupancy), 4);
        for (int k = 0; k < 4; k++) do_exec(3'(k), 16'(10 + k));

        // R5 commit two, cache blocked (R7)
        do_commit(11);
        settle();
        chk("R5 wb_pending", 64'(wb_pending), 2);
        chk("R7 no write while blocked", 64'(wb_valid), 0);

        // R9 squash younger uncommitted
        do_squash(11);
        settle();
        chk("R9 occupancy after squash", 64'(occupancy), 2);
        chk("R9 tail pulled back", 64'(alloc_idx), 2);
        do_squash(5);
        settle();
        chk("R9 committed kept", 64'(occupancy), 2);
        chk("R9 pending kept", 64'(wb_pending), 2);

        // R6 drain, R8 not freed at issue
        drain(3);
        chk("R6 wb_pending drained", 64'(wb_pending), 0);
        chk("R6 scoreboard empty", 64'(sb_q.size()), 0);
        chk("R8 not freed at issue", 64'(occupancy), 2);

        // R8 out-of-order completion
        do_done(1);
        settle();
        chk("R8 younger done holds", 64'(occupancy), 2);
        settle();
        chk("R8 younger done holds later", 64'(occupancy), 2);
        do_done(0);
        settle();
        chk("R8 one cycle latency", 64'(occupancy), 2);
        settle();
        chk("R8 contiguous release", 64'(occupancy), 0);

        // R10 wrap, R3 full
        for (int k = 0; k < 7; k++)
            do_alloc(16'(20 + k), 3'((2 + k) % 8), "R10 wrapped alloc_idx");
        settle();
        chk("R3 occupancy at limit", 64'(occupancy), 7);
        chk("R3 full", 64'(full), 1);
        do_alloc(40, 3'd1, "R10 alloc_idx after wrap");
        settle();
        chk("R3 alloc ignored count", 64'(occupancy), 7);
        chk("R3 alloc ignored idx", 64'(alloc_idx), 1);

        for (int k = 0; k < 7; k++) do_exec(3'((2 + k) % 8), 16'(20 + k));
        do_commit(26);
        settle();
        chk("R5 seven committed", 64'(wb_pending), 7);
        drain(9);
        chk("R6 wrap drained", 64'(wb_pending), 0);
        chk("R6 wrap scoreboard empty", 64'(sb_q.size()), 0);
        chk("R8 still held", 64'(occupancy), 7);
        for (int k = 0; k < 7; k++) do_done(3'((2 + k) % 8));
        settle();
        settle();
        chk("R8 all released", 64'(occupancy), 0);
        chk("R3 full cleared", 64'(full), 0);

        // R11 alloc with squash in same cycle
        @(negedge clk);
        clear_in();
        alloc_valid = 1; alloc_tag = 50; squash_valid = 1; squash_tag = 0;
        settle();
        chk("R11 alloc ignored count", 64'(occupancy), 0);
        chk("R11 alloc ignored idx", 64'(alloc_idx), 1);

        // R5 repeated commit
        do_alloc(51, 3'd1, "R2 alloc_idx");
        do_alloc(52, 3'd2, "R2 alloc_idx");
        do_exec(3'd1, 51);
        do_exec(3'd2, 52);
        do_commit(51);
        settle();
        chk("R5 one committed", 64'(wb_pending), 1);
        do_commit(51);
        settle();
        chk("R5 repeat commit no change", 64'(wb_pending), 1);
        do_commit(52);
        settle();
        chk("R5 second committed", 64'(wb_pending), 2);
        drain(4);
        chk("R6 final drain", 64'(wb_pending), 0);
        chk("R6 final scoreboard empty", 64'(sb_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule